// File: doc/BRIEF.md
# Level Interrupt Aggregator

The block gathers a set of level-sensitive interrupt request lines into a single processor interrupt. A line becomes pending when it rises and stays pending while it stays high. It drops out of pending as soon as it goes low. Each line has an enable bit, and the output interrupt is raised whenever at least one pending line is also enabled.

Software reaches the block through a small word-wide register window with separate read and write strobes. Reads return combinationally in the strobe cycle. Writes take effect at the clock edge that samples them. Software can set enable bits, clear enable bits, or wipe both the enables and the pending vector in one write. It can read the enabled pending lines as a mask or as a count. Each line also has an event counter, read through a separate debug select and data port. The counter advances once per rising edge of its line and wraps on overflow.

Top module: `irq_aggregator`

## Requirements
- R1: While reset is asserted and directly after it, the pending vector, the enable mask and every event counter are zero, and `irq_out` is low.
- R2: A write to offset 0x10 ORs `bus_wdata` into the enable mask.
- R3: A write to offset 0x0C clears each enable bit whose `bus_wdata` bit is 1 and leaves the others unchanged.
- R4: A write to offset 0x08 clears the enable mask and the pending vector whatever `bus_wdata` holds. This clear wins over a line that rises in the same cycle.
- R5: A line's pending bit is set by a rising edge of the line and stays set while the line stays high. It is cleared in the cycle after the line is sampled low. A line that is held high after a disable-all write stays not pending until it falls and rises again.
- R6: A read of offset 0x04 returns pending AND enable, never the raw pending vector.
- R7: A read of offset 0x00 returns the number of lines that are both pending and enabled, zero-extended to 32 bits.
- R8: `irq_out` is registered. After each clock edge it is high exactly when pending AND enable is nonzero. It reflects an input change or a write one edge after the change or write is sampled.
- R9: Each line's 32-bit event counter increases by one for each rising edge of that line. Holding the line high adds nothing. `dbg_count` shows the counter of the line chosen by `dbg_sel`.
- R10: Reads of offsets 0x08, 0x0C, 0x10 and any offset other than 0x00 and 0x04 return zero. Writes to offsets other than 0x08, 0x0C and 0x10 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | NUM_LINES | Level interrupt requests, synchronous to clk |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte offset of the word accessed |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of bus_rd |
| irq_out | output | 1 | Aggregated interrupt to the processor |
| dbg_sel | input | SEL_W | Line whose event counter is shown |
| dbg_count | output | CNT_W | Event counter of the selected line |

## Verification
Two events can land on the same clock edge: a register write and a change on the request lines. The sharpest case is a disable-all write in the cycle where a line rises. The bench provokes it on purpose, then re-enables that line while it is still high and expects no interrupt, no pending bit and yet one more counted event. It also pairs enable writes with rising lines, and lets a pseudo-random sequence mix writes with line changes. After every edge a scoreboard compares the interrupt, the masked vector and the count against a model that applies the line update first and the write second.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int NUM_LINES = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 6,
  parameter int CNT_W     = 32,
  parameter int SEL_W     = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_lines,
  input  logic                 bus_rd,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 irq_out,
  input  logic [SEL_W-1:0]     dbg_sel,
  output logic [CNT_W-1:0]     dbg_count
);
  localparam int POP_W = $clog2(NUM_LINES + 1);
  localparam logic [ADDR_W-1:0] OFS_COUNT  = ADDR_W'(6'h00);
  localparam logic [ADDR_W-1:0] OFS_MASKED = ADDR_W'(6'h04);
  localparam logic [ADDR_W-1:0] OFS_KILL   = ADDR_W'(6'h08);
  localparam logic [ADDR_W-1:0] OFS_CLR    = ADDR_W'(6'h0C);
  localparam logic [ADDR_W-1:0] OFS_SET    = ADDR_W'(6'h10);

  logic [NUM_LINES-1:0] pend_q, en_q, line_q;
  logic [NUM_LINES-1:0] pend_d, en_d, rising, masked;
  logic [POP_W-1:0]     act_cnt;
  logic [CNT_W-1:0]     cnt_q [NUM_LINES];

  wire wr_kill = bus_wr && bus_addr == OFS_KILL;
  wire wr_clr  = bus_wr && bus_addr == OFS_CLR;
  wire wr_set  = bus_wr && bus_addr == OFS_SET;

  assign rising = irq_lines & ~line_q;
  assign masked = pend_q & en_q;

  always_comb begin
    pend_d = (pend_q | rising) & irq_lines;
    en_d   = en_q;
    if (wr_set) en_d = en_q | bus_wdata[NUM_LINES-1:0];
    if (wr_clr) en_d = en_q & ~bus_wdata[NUM_LINES-1:0];
    if (wr_kill) begin
      en_d   = '0;
      pend_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      en_q    <= '0;
      line_q  <= '0;
      irq_out <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      en_q    <= en_d;
      line_q  <= irq_lines;
      irq_out <= |(pend_d & en_d);
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q[g] <= '0;
      else if (rising[g]) cnt_q[g] <= cnt_q[g] + 1'b1;
    end
  end

  always_comb begin
    act_cnt = '0;
    for (int i = 0; i < NUM_LINES; i++) act_cnt = act_cnt + POP_W'(masked[i]);
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == OFS_COUNT)  bus_rdata = DATA_W'(act_cnt);
      if (bus_addr == OFS_MASKED) bus_rdata = DATA_W'(masked);
    end
  end

  assign dbg_count = cnt_q[dbg_sel];
endmodule

module irq_aggregator_chk #(
  parameter int NUM_LINES = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 6,
  parameter int CNT_W     = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_LINES-1:0] irq_lines,
  input logic                 bus_wr,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic                 irq_out,
  input logic [NUM_LINES-1:0] pend_q,
  input logic [NUM_LINES-1:0] en_q,
  input logic [CNT_W-1:0]     cnt0
);
  localparam logic [ADDR_W-1:0] A_KILL = ADDR_W'(6'h08);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(6'h0C);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(6'h10);
  wire [NUM_LINES-1:0] wmask = bus_wdata[NUM_LINES-1:0];

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (pend_q == '0 && en_q == '0 && !irq_out && cnt0 == '0));

  p_enable_or_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_SET) |=> ((en_q & $past(wmask)) == $past(wmask)));

  p_disable_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CLR) |=> ((en_q & $past(wmask)) == '0));

  p_kill_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_KILL) |=> (en_q == '0 && pend_q == '0));

  p_pend_follows_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(irq_lines)) == '0));

  p_irq_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == ((pend_q & en_q) != '0));

  p_count_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_lines[0]) |=> (cnt0 == $past(cnt0) + 1'b1));

  p_count_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lines[0] && $past(irq_lines[0])) |=> $stable(cnt0));
endmodule

bind irq_aggregator irq_aggregator_chk #(
  .NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_out(irq_out),
  .pend_q(pend_q), .en_q(en_q), .cnt0(cnt_q[0])
);

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq_lines = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;
  logic [4:0]  dbg_sel = '0;
  logic [31:0] dbg_count;

  always #5 clk = ~clk;

  irq_aggregator i_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out), .dbg_sel(dbg_sel),
    .dbg_count(dbg_count)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb[$];

  logic [N-1:0] lines_m = '0, en_m = '0, pend_m = '0;
  logic [31:0]  cnt_m [N];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (bus_rd) begin
      if (sb.size() == 0) check(1'b0, "scoreboard underflow", bus_rdata, 32'h0);
      else begin
        item_t it;
        it = sb.pop_front();
        check(bus_rdata === it.exp, it.tag, bus_rdata, it.exp);
      end
    end
  end

  function automatic logic [31:0] popc(input logic [N-1:0] v);
    logic [31:0] c = 0;
    for (int i = 0; i < N; i++) c += 32'(v[i]);
    return c;
  endfunction

  task automatic step(input logic [N-1:0] v, input bit wr, input logic [5:0] a, input logic [31:0] d);
    logic [N-1:0] rise;
    irq_lines = v; bus_wr = wr; bus_addr = a; bus_wdata = d;
    rise = v & ~lines_m;
    for (int i = 0; i < N; i++) if (rise[i]) cnt_m[i]++;
    pend_m = (pend_m | rise) & v;
    lines_m = v;
    if (wr) begin
      if (a == 6'h08) begin en_m = '0; pend_m = '0; end
      if (a == 6'h0C) en_m = en_m & ~d;
      if (a == 6'h10) en_m = en_m | d;
    end
    @(posedge clk); #1;
    bus_wr = 1'b0;
    check(irq_out === |(pend_m & en_m), "R8 irq_out", 32'(irq_out), 32'(|(pend_m & en_m)));
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic rd_state(input string tag);
    rd(6'h04, pend_m & en_m, {tag, " R6 masked pending"});
    rd(6'h00, popc(pend_m & en_m), {tag, " R7 count"});
  endtask

  task automatic chk_counter(input int i, input string tag);
    dbg_sel = 5'(i); #1;
    check(dbg_count === cnt_m[i], tag, dbg_count, cnt_m[i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf = 32'h1ACE_B00C;
    for (int i = 0; i < N; i++) cnt_m[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    check(irq_out === 1'b0, "R1 irq low in reset", 32'(irq_out), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(irq_out === 1'b0, "R1 irq low after reset", 32'(irq_out), 0);
    rd_state("R1");
    chk_counter(0, "R1 counter 0");
    chk_counter(31, "R1 counter 31");

    step(32'h5, 1'b1, 6'h10, 32'h1);
    rd_state("R2 enable with rise");
    step(32'h5, 1'b1, 6'h10, 32'hF0);
    step(32'hF5, 1'b0, 6'h00, 0);
    rd_state("R2 accumulate");
    step(32'hF5, 1'b1, 6'h0C, 32'h30);
    rd_state("R3 disable");
    step(32'hC4, 1'b0, 6'h00, 0);
    rd_state("R5 line low clears");
    repeat (5) step(32'hC4, 1'b0, 6'h00, 0);
    chk_counter(2, "R9 held line counted once");
    chk_counter(0, "R9 line 0 counted once");

    step(32'h1C4, 1'b1, 6'h08, 32'h0);
    rd_state("R4 kill with data zero");
    step(32'h1C4, 1'b1, 6'h10, 32'hFFFF_FFFF);
    rd_state("R5 held high stays clear");
    check(irq_out === 1'b0, "R4 no irq after kill", 32'(irq_out), 0);
    chk_counter(8, "R9 rise during kill counted");
    step(32'h0C4, 1'b0, 6'h00, 0);
    step(32'h1C4, 1'b0, 6'h00, 0);
    rd_state("R5 re-rise pends");

    step(32'h1C4, 1'b1, 6'h00, 32'h0);
    step(32'h1C4, 1'b1, 6'h04, 32'h0);
    step(32'h1C4, 1'b1, 6'h14, 32'h0);
    step(32'h1C4, 1'b1, 6'h20, 32'h0);
    rd_state("R10 ignored writes");
    rd(6'h08, 0, "R10 read kill offset");
    rd(6'h0C, 0, "R10 read clear offset");
    rd(6'h10, 0, "R10 read set offset");
    rd(6'h14, 0, "R10 read unmapped");
    rd(6'h3C, 0, "R10 read beyond window");

    for (int k = 0; k < 300; k++) begin
      logic [N-1:0] v;
      logic [5:0] a;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      v = lines_m ^ (lf & {lf[7:0], lf[31:8]} & 32'h9249_2493);
      case (lf[3:1])
        3'd0: a = 6'h08;
        3'd1, 3'd2: a = 6'h0C;
        3'd3, 3'd4, 3'd5: a = 6'h10;
        default: a = 6'h14;
      endcase
      step(v, lf[9] | lf[4], a, {lf[15:0], lf[31:16]});
      if (k % 10 == 0) rd_state("R5 R7 random");
    end
    for (int i = 0; i < N; i++) chk_counter(i, "R9 final counter");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule